// File: doc/BRIEF.md
# Shared-Address UART Data Port

This block is the processor-side data path of a simple asynchronous serial port. A single bus location serves both directions. A write places a byte in a transmit holding buffer. A read returns the most recently completed received byte. Because the two directions share the address, reading it never returns what was last written. Each access has a side effect: a read clears the receive-full flag, and a write clears the transmit-empty flag.

The block contains a transmit shifter and a receive shifter running from a fixed clock divider. Frames carry one start bit, seven or eight data bits sent least significant bit first, and one stop bit. The held byte moves into the transmit shifter as soon as the shifter is idle and transmission is enabled. Completed receive frames land in the receive buffer. Overrun and framing faults are flagged and stay set until a dedicated clear input is pulsed. Receive and transmit interrupt requests are level outputs built from the flags and their enables.

Top module: `serial_data_port`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, ovr_err and frm_err are 0, bus_rdata is 0 and ser_out is 1 (idle line).
- R2: A read access (bus_sel=1, bus_we=0) returns the receive buffer on bus_rdata, never the value last written.
- R3: When a receive frame completes while rx_full is 0, its data goes into the receive buffer and rx_full becomes 1.
- R4: A read access clears rx_full on that clock edge. rx_irq equals rx_ie AND (rx_full OR ovr_err OR frm_err), so a read clears the request only when no error flag is set.
- R5: With len7=1, seven data bits are received and bit 7 of the stored byte reads as 0.
- R6: A write access (bus_sel=1, bus_we=1) clears tx_empty on that edge. tx_empty returns to 1 on the edge where the held byte moves into the transmit shifter.
- R7: A transmitted frame is a 0 start bit, then the data bits least significant first, then a 1 stop bit, each lasting CLKS_PER_BIT clocks. With len7=1 only bits 0 to 6 are sent, so the stop bit directly follows bit 6.
- R8: tx_irq equals tx_ie AND tx_empty at all times.
- R9: If a frame completes while rx_full is 1 and no read occurs in that cycle, ovr_err becomes 1, the buffer keeps the old byte, and ovr_err stays set until err_clr is pulsed.
- R10: A frame whose stop bit samples as 0 is stored with rx_full set and raises frm_err, which stays set until err_clr is pulsed.
- R11: While tx_en is 0, a written byte is held, tx_empty stays 0 and ser_out stays 1. Once tx_en is 1, the byte is sent.
- R12: While rx_en is 0, line activity does not start a frame: rx_full stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Data-location access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write transmit byte, 0 = read receive byte |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Receive buffer contents |
| len7 | input | 1 | 1 = seven-bit data, 0 = full DATA_W bits |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| err_clr | input | 1 | Pulse to clear ovr_err and frm_err |
| tx_empty | output | 1 | Holding buffer can take a new byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| ovr_err | output | 1 | Overrun seen |
| frm_err | output | 1 | Framing fault seen |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |

## Verification
The bench builds the port with DATA_W=8, CLKS_PER_BIT=8 and SYNC_STAGES=2. These values make every byte value reachable in both lengths: all 256 codes are sent and received in eight-bit mode and all 128 in seven-bit mode, and each bit cell is short enough that a full sweep stays brief. A divider of 8 still leaves room for the synchronizer delay inside a half bit, so the centre-sampling corner is covered. Overrun, framing, disabled-direction and simultaneous flag behaviour are each driven once, with the expected flags worked out per cycle.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   typedef enum logic [1:0] {
      LN_IDLE  = 2'd0,
      LN_START = 2'd1,
      LN_DATA  = 2'd2,
      LN_STOP  = 2'd3
   } line_state_e;
endpackage

// File: rtl/sdp_tx_shift.sv
module sdp_tx_shift
   import sdp_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CLKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              short_i,
   output logic              idle_o,
   output logic              ser_o
);
   localparam int unsigned DIV_W = $clog2(CLKS_PER_BIT);
   localparam int unsigned CNT_W = $clog2(DATA_W + 1);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_BIT - 1);
   localparam logic [CNT_W-1:0] N_FULL   = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] N_SHORT  = CNT_W'(DATA_W - 1);

   line_state_e       state_q;
   logic [DIV_W-1:0]  div_q;
   logic [CNT_W-1:0]  bit_q;
   logic [CNT_W-1:0]  last_q;
   logic [DATA_W-1:0] shreg_q;
   logic              ser_q;
   logic              tick;

   assign tick   = (div_q == DIV_LAST);
   assign idle_o = (state_q == LN_IDLE);
   assign ser_o  = ser_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LN_IDLE;
         div_q   <= '0;
         bit_q   <= '0;
         last_q  <= '0;
         shreg_q <= '0;
         ser_q   <= 1'b1;
      end else begin
         case (state_q)
            LN_IDLE: begin
               if (load_i) begin
                  shreg_q <= data_i;
                  last_q  <= (short_i ? N_SHORT : N_FULL) - CNT_W'(1);
                  div_q   <= '0;
                  bit_q   <= '0;
                  ser_q   <= 1'b0;
                  state_q <= LN_START;
               end
            end
            LN_START: begin
               if (tick) begin
                  div_q   <= '0;
                  ser_q   <= shreg_q[0];
                  state_q <= LN_DATA;
               end else begin
                  div_q <= div_q + DIV_W'(1);
               end
            end
            LN_DATA: begin
               if (tick) begin
                  div_q <= '0;
                  if (bit_q == last_q) begin
                     ser_q   <= 1'b1;
                     state_q <= LN_STOP;
                  end else begin
                     ser_q   <= shreg_q[1];
                     shreg_q <= shreg_q >> 1;
                     bit_q   <= bit_q + CNT_W'(1);
                  end
               end else begin
                  div_q <= div_q + DIV_W'(1);
               end
            end
            default: begin
               if (tick) begin
                  div_q   <= '0;
                  state_q <= LN_IDLE;
               end else begin
                  div_q <= div_q + DIV_W'(1);
               end
            end
         endcase
      end
   end

   // R7: a load from idle drives the start bit on the next edge
   a_r7_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && idle_o) |=> !ser_o);

   // R7: the line is released high whenever the shifter rests
   a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(idle_o)) |-> ser_o);
endmodule

// File: rtl/sdp_rx_shift.sv
module sdp_rx_shift
   import sdp_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CLKS_PER_BIT = 16,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              short_i,
   input  logic              ser_i,
   output logic              done_o,
   output logic              stop_ok_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int unsigned DIV_W = $clog2(CLKS_PER_BIT);
   localparam int unsigned CNT_W = $clog2(DATA_W + 1);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_BIT - 1);
   localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLKS_PER_BIT / 2 - 1);
   localparam logic [CNT_W-1:0] N_FULL   = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] N_SHORT  = CNT_W'(DATA_W - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line;
   logic                   prev_q;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= ser_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   assign line = sync_q[SYNC_STAGES-1];

   line_state_e       state_q;
   logic [DIV_W-1:0]  div_q;
   logic [CNT_W-1:0]  bit_q;
   logic [CNT_W-1:0]  last_q;
   logic              short_q;
   logic [DATA_W-1:0] shreg_q;
   logic              tick;

   assign tick = (div_q == DIV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= LN_IDLE;
         prev_q    <= 1'b1;
         div_q     <= '0;
         bit_q     <= '0;
         last_q    <= '0;
         short_q   <= 1'b0;
         shreg_q   <= '0;
         done_o    <= 1'b0;
         stop_ok_o <= 1'b0;
         data_o    <= '0;
      end else begin
         prev_q <= line;
         done_o <= 1'b0;
         case (state_q)
            LN_IDLE: begin
               if (en_i && prev_q && !line) begin
                  div_q   <= '0;
                  bit_q   <= '0;
                  shreg_q <= '0;
                  short_q <= short_i;
                  last_q  <= (short_i ? N_SHORT : N_FULL) - CNT_W'(1);
                  state_q <= LN_START;
               end
            end
            LN_START: begin
               if (div_q == DIV_HALF) begin
                  div_q   <= '0;
                  state_q <= line ? LN_IDLE : LN_DATA;
               end else begin
                  div_q <= div_q + DIV_W'(1);
               end
            end
            LN_DATA: begin
               if (tick) begin
                  div_q   <= '0;
                  shreg_q <= {line, shreg_q[DATA_W-1:1]};
                  bit_q   <= bit_q + CNT_W'(1);
                  if (bit_q == last_q) state_q <= LN_STOP;
               end else begin
                  div_q <= div_q + DIV_W'(1);
               end
            end
            default: begin
               if (tick) begin
                  div_q     <= '0;
                  done_o    <= 1'b1;
                  stop_ok_o <= line;
                  data_o    <= short_q ? (shreg_q >> 1) : shreg_q;
                  state_q   <= LN_IDLE;
               end else begin
                  div_q <= div_q + DIV_W'(1);
               end
            end
         endcase
      end
   end

   // R12: no frame activity starts while reception is disabled
   a_r12_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && state_q == LN_IDLE) |=> (state_q == LN_IDLE));
endmodule

// File: rtl/serial_data_port.sv
module serial_data_port #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CLKS_PER_BIT = 16,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              len7,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              tx_ie,
   input  logic              rx_ie,
   input  logic              err_clr,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              ovr_err,
   output logic              frm_err,
   output logic              tx_irq,
   output logic              rx_irq,
   input  logic              ser_in,
   output logic              ser_out
);
   if (DATA_W < 2) begin : g_bad_width
      $error("serial_data_port: DATA_W must be at least 2");
   end
   if (CLKS_PER_BIT < 4) begin : g_bad_div
      $error("serial_data_port: CLKS_PER_BIT must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("serial_data_port: SYNC_STAGES must be at least 2");
   end

   logic              rd_acc;
   logic              wr_acc;
   logic [DATA_W-1:0] hold_q;
   logic              tx_empty_q;
   logic              tx_idle;
   logic              tx_load;
   logic              rx_done;
   logic              rx_stop_ok;
   logic [DATA_W-1:0] rx_data;
   logic [DATA_W-1:0] rx_buf_q;
   logic              rx_full_q;
   logic              ovr_q;
   logic              frm_q;

   assign rd_acc  = bus_sel && !bus_we;
   assign wr_acc  = bus_sel && bus_we;
   assign tx_load = !tx_empty_q && tx_idle && tx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= '0;
         tx_empty_q <= 1'b1;
      end else if (wr_acc) begin
         hold_q     <= bus_wdata;
         tx_empty_q <= 1'b0;
      end else if (tx_load) begin
         tx_empty_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf_q  <= '0;
         rx_full_q <= 1'b0;
         ovr_q     <= 1'b0;
         frm_q     <= 1'b0;
      end else begin
         if (err_clr) begin
            ovr_q <= 1'b0;
            frm_q <= 1'b0;
         end
         if (rx_done) begin
            if (rx_full_q && !rd_acc) begin
               ovr_q <= 1'b1;
            end else begin
               rx_buf_q  <= rx_data;
               rx_full_q <= 1'b1;
               if (!rx_stop_ok) frm_q <= 1'b1;
            end
         end else if (rd_acc) begin
            rx_full_q <= 1'b0;
         end
      end
   end

   sdp_tx_shift #(
      .DATA_W       (DATA_W),
      .CLKS_PER_BIT (CLKS_PER_BIT)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (tx_load),
      .data_i  (hold_q),
      .short_i (len7),
      .idle_o  (tx_idle),
      .ser_o   (ser_out)
   );

   sdp_rx_shift #(
      .DATA_W       (DATA_W),
      .CLKS_PER_BIT (CLKS_PER_BIT),
      .SYNC_STAGES  (SYNC_STAGES)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (rx_en),
      .short_i   (len7),
      .ser_i     (ser_in),
      .done_o    (rx_done),
      .stop_ok_o (rx_stop_ok),
      .data_o    (rx_data)
   );

   assign bus_rdata = rx_buf_q;
   assign tx_empty  = tx_empty_q;
   assign rx_full   = rx_full_q;
   assign ovr_err   = ovr_q;
   assign frm_err   = frm_q;
   assign tx_irq    = tx_ie && tx_empty_q;
   assign rx_irq    = rx_ie && (rx_full_q || ovr_q || frm_q);

   // R6: a write always leaves the holding buffer occupied
   a_r6_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> !tx_empty);

   // R4: a read with no arriving frame empties the receive buffer
   a_r4_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && !rx_done) |=> !rx_full);

   // R3: a finished frame always leaves the buffer full
   a_r3_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> rx_full);

   // R9: overrun raises the error and preserves the old byte
   a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full && !rd_acc) |=> (ovr_err && $stable(bus_rdata)));

   // R11: with transmit disabled only a write can change tx_empty
   a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !wr_acc) |=> (tx_empty == $past(tx_empty)));

   // R5: in seven-bit mode a newly stored byte has a clear top bit
   a_r5_short_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && len7 && !(rx_full && !rd_acc)) |=> !bus_rdata[DATA_W-1]);
endmodule

// File: tb/serial_data_port_test.sv
`timescale 1ns/1ps
module serial_data_port_test;
   localparam int DW  = 8;
   localparam int CPB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          len7 = 1'b0;
   logic          tx_en = 1'b1;
   logic          rx_en = 1'b1;
   logic          tx_ie = 1'b0;
   logic          rx_ie = 1'b0;
   logic          err_clr = 1'b0;
   logic          tx_empty, rx_full, ovr_err, frm_err, tx_irq, rx_irq;
   logic          ser_in = 1'b1;
   logic          ser_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   serial_data_port #(.DATA_W(DW), .CLKS_PER_BIT(CPB), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .len7(len7),
      .tx_en(tx_en), .rx_en(rx_en), .tx_ie(tx_ie), .rx_ie(rx_ie),
      .err_clr(err_clr), .tx_empty(tx_empty), .rx_full(rx_full),
      .ovr_err(ovr_err), .frm_err(frm_err), .tx_irq(tx_irq), .rx_irq(rx_irq),
      .ser_in(ser_in), .ser_out(ser_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [DW-1:0] v);
      bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = v;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(output logic [DW-1:0] v);
      bus_sel = 1'b1; bus_we = 1'b0;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic send_frame(input logic [DW-1:0] v, input int nb, input logic stop);
      ser_in = 1'b0;
      repeat (CPB) @(negedge clk);
      for (int b = 0; b < nb; b++) begin
         ser_in = v[b];
         repeat (CPB) @(negedge clk);
      end
      ser_in = stop;
      repeat (CPB) @(negedge clk);
      ser_in = 1'b1;
      repeat (2 * CPB) @(negedge clk);
   endtask

   task automatic get_frame(input int nb, output logic [DW-1:0] v, output logic stop,
                            output bit found);
      found = 1'b0;
      v = '0;
      stop = 1'b0;
      for (int i = 0; i < 400 && !found; i++) begin
         @(negedge clk);
         if (!ser_out) found = 1'b1;
      end
      if (found) begin
         for (int b = 0; b < nb; b++) begin
            repeat (CPB) @(negedge clk);
            v[b] = ser_out;
         end
         repeat (CPB) @(negedge clk);
         stop = ser_out;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] got;
      logic [DW-1:0] expv;
      logic          stp;
      bit            fnd;
      bit            line_ok;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(tx_empty === 1'b1, "R1 tx_empty", tx_empty, 1);
      check(rx_full === 1'b0, "R1 rx_full", rx_full, 0);
      check(ovr_err === 1'b0 && frm_err === 1'b0, "R1 errors", {ovr_err, frm_err}, 0);
      check(bus_rdata === '0, "R1 rdata", bus_rdata, 0);
      check(ser_out === 1'b1, "R1 ser_out", ser_out, 1);

      // R8: transmit request follows enable and empty flag
      check(tx_irq === 1'b0, "R8 irq off", tx_irq, 0);
      tx_ie = 1'b1;
      #1 check(tx_irq === 1'b1, "R8 irq on", tx_irq, 1);

      // R11: write held while transmit is off
      tx_en = 1'b0;
      @(negedge clk);
      bus_write(8'h3C);
      check(tx_empty === 1'b0, "R11 empty low", tx_empty, 0);
      check(tx_irq === 1'b0, "R8 irq drops", tx_irq, 0);
      line_ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (ser_out !== 1'b1 || tx_empty !== 1'b0) line_ok = 1'b0;
      end
      check(line_ok, "R11 held idle", line_ok, 1);
      tx_en = 1'b1;
      get_frame(8, got, stp, fnd);
      check(fnd && got === 8'h3C && stp === 1'b1, "R11 sent after enable", got, 8'h3C);
      check(tx_empty === 1'b1, "R6 empty after load", tx_empty, 1);

      // R7 R6: full eight-bit transmit sweep
      for (int v = 0; v < 256; v++) begin
         bus_write(DW'(v));
         check(tx_empty === 1'b0, "R6 write clears", tx_empty, 0);
         get_frame(8, got, stp, fnd);
         check(fnd && got === DW'(v) && stp === 1'b1, "R7 tx8 frame", got, v);
      end

      // R7: seven-bit transmit sweep, top bit set on odd values
      len7 = 1'b1;
      repeat (2 * CPB) @(negedge clk);
      for (int v = 0; v < 128; v++) begin
         bus_write(DW'(v) | (DW'(v & 1) << 7));
         get_frame(7, got, stp, fnd);
         check(fnd && got === DW'(v) && stp === 1'b1, "R7 tx7 frame", {got, 7'(0), stp}, v);
      end
      len7 = 1'b0;
      tx_ie = 1'b0;
      repeat (2 * CPB) @(negedge clk);

      // R3 R4: eight-bit receive sweep
      rx_ie = 1'b1;
      for (int v = 0; v < 256; v++) begin
         send_frame(DW'(v), 8, 1'b1);
         check(rx_full === 1'b1 && rx_irq === 1'b1, "R3 full after frame", rx_full, 1);
         bus_read(got);
         check(got === DW'(v), "R3 rx8 data", got, v);
         check(rx_full === 1'b0 && rx_irq === 1'b0, "R4 read clears", {rx_full, rx_irq}, 0);
      end

      // R5: seven-bit receive sweep, eighth data bit never sent
      len7 = 1'b1;
      for (int v = 0; v < 128; v++) begin
         send_frame(DW'(v) | 8'h80, 7, 1'b1);
         bus_read(got);
         expv = DW'(v);
         check(got === expv, "R5 rx7 data", got, expv);
      end
      len7 = 1'b0;

      // R2: read returns receive buffer, not the written byte
      send_frame(8'h5A, 8, 1'b1);
      bus_write(8'hA5);
      get_frame(8, got, stp, fnd);
      bus_read(got);
      check(got === 8'h5A, "R2 read not write", got, 8'h5A);

      // R9: overrun keeps old byte and holds until cleared
      send_frame(8'h11, 8, 1'b1);
      send_frame(8'h22, 8, 1'b1);
      check(ovr_err === 1'b1 && rx_full === 1'b1, "R9 overrun set", {ovr_err, rx_full}, 3);
      bus_read(got);
      check(got === 8'h11, "R9 old byte kept", got, 8'h11);
      check(rx_full === 1'b0 && rx_irq === 1'b1, "R4 irq held by error", {rx_full, rx_irq}, 1);
      repeat (5) @(negedge clk);
      check(ovr_err === 1'b1, "R9 sticky", ovr_err, 1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      check(ovr_err === 1'b0 && rx_irq === 1'b0, "R9 cleared", {ovr_err, rx_irq}, 0);

      // R10: bad stop bit
      send_frame(8'h6D, 8, 1'b0);
      check(frm_err === 1'b1 && rx_full === 1'b1, "R10 frame err", {frm_err, rx_full}, 3);
      bus_read(got);
      check(got === 8'h6D, "R10 data stored", got, 8'h6D);
      check(rx_irq === 1'b1, "R10 irq held", rx_irq, 1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      check(frm_err === 1'b0 && rx_irq === 1'b0, "R10 cleared", {frm_err, rx_irq}, 0);
      send_frame(8'h4E, 8, 1'b1);
      bus_read(got);
      check(got === 8'h4E && frm_err === 1'b0, "R10 recovers", got, 8'h4E);

      // R12: receiver disabled ignores the line
      rx_en = 1'b0;
      send_frame(8'h77, 8, 1'b1);
      check(rx_full === 1'b0, "R12 ignored", rx_full, 0);
      check(bus_rdata === 8'h4E, "R12 buffer kept", bus_rdata, 8'h4E);
      rx_en = 1'b1;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule